// File: doc/BRIEF.md
# Steerable Mirrored Fork

This block takes a single input stream under a valid/ready handshake and copies each accepted word onto N output streams. Each output has its own valid/ready pair, and every downstream consumer may take the word in a cycle of its own choosing. All outputs carry the same data word.

A destination mask, one bit per output, is sampled in the same cycle as the input handshake. It steers the word to a subset of the outputs. An all-zero mask broadcasts the word to every output. The block registers the word together with a pending bitmask. It raises input ready again only after every selected output has taken the word, so it moves at most one word per full acknowledgement round.

Top module: `mirror_fork`

## Requirements
- R1: After reset (rst_ni low), every out_valid_o bit is 0 and in_ready_o is 1.
- R2: When in_valid_i and in_ready_o are both 1 at a rising edge, the word is captured. From the next cycle, out_data_o equals the captured word for every output.
- R3: On capture with a non-zero dst_mask_i, out_valid_o equals dst_mask_i from the next cycle. Bit k of dst_mask_i selects output k.
- R4: On capture with dst_mask_i equal to zero, every out_valid_o bit is 1 from the next cycle.
- R5: Bit k of out_valid_o falls in the cycle after a rising edge at which out_valid_o[k] and out_ready_i[k] are both 1. The other bits are unaffected.
- R6: in_ready_o is 1 exactly when no out_valid_o bit is 1. While any output is pending, in_valid_i and dst_mask_i have no effect on the outputs.
- R7: While out_valid_o[k] is 1 and out_ready_i[k] is 0, the bit stays 1 and out_data_o stays unchanged.
- R8: When the last pending outputs are acknowledged in the same edge, in_ready_o is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input ready |
| in_data_i | input | DW | Input word |
| dst_mask_i | input | N | Destination mask; all zeros means broadcast |
| out_valid_o | output | N | Per-output valid |
| out_ready_i | input | N | Per-output ready |
| out_data_o | output | DW | Mirrored data word |

## Verification
The bench targets these corner cases:
- **Zero-mask broadcast.** A design that treats the zero mask as literal would drop the word and never raise any out_valid_o bit.
- **One acknowledgement among several.** Stalled outputs are held while one output acknowledges. A design that clears the wrong bit, or clears all bits, would lose or duplicate deliveries.
- **Input offered while busy.** The input is offered with a new word and mask while outputs are still pending. A design that accepts early would overwrite data that a slow consumer has not yet seen.
- **Simultaneous final acknowledgements.** Several outputs take the last word at the same edge, and a back-to-back word follows at once. This checks that in_ready_o returns exactly one cycle later.

// File: rtl/mirror_fork_pkg.sv
package mirror_fork_pkg;
  localparam int unsigned DEF_N  = 4;
  localparam int unsigned DEF_DW = 16;
endpackage

// File: rtl/mirror_fork_slot.sv
module mirror_fork_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic sel_i,
  input  logic ready_i,
  output logic valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                valid_o <= 1'b0;
    else if (load_i)            valid_o <= sel_i;
    else if (valid_o && ready_i) valid_o <= 1'b0;
  end

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !load_i) |=> valid_o);
  // R5
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !load_i) |=> !valid_o);
endmodule

// File: rtl/mirror_fork_ctrl.sv
module mirror_fork_ctrl #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [N-1:0] dst_mask_i,
  input  logic [N-1:0] pending_i,
  output logic         in_ready_o,
  output logic         load_o,
  output logic [N-1:0] sel_o
);
  assign in_ready_o = (pending_i == '0);
  assign load_o     = in_valid_i && in_ready_o;
  // zero mask broadcasts
  assign sel_o      = (dst_mask_i == '0) ? {N{1'b1}} : dst_mask_i;

  // R4
  bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && dst_mask_i == '0) |=> (pending_i == {N{1'b1}}));
  // R3
  steer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && dst_mask_i != '0) |=> (pending_i == $past(dst_mask_i)));
endmodule

// File: rtl/mirror_fork.sv
module mirror_fork
  import mirror_fork_pkg::*;
#(
  parameter int unsigned N  = DEF_N,
  parameter int unsigned DW = DEF_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  input  logic [N-1:0]  dst_mask_i,
  output logic [N-1:0]  out_valid_o,
  input  logic [N-1:0]  out_ready_i,
  output logic [DW-1:0] out_data_o
);
  logic         load;
  logic [N-1:0] sel;
  logic [DW-1:0] data_q;

  mirror_fork_ctrl #(.N(N)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .dst_mask_i(dst_mask_i), .pending_i(out_valid_o),
    .in_ready_o(in_ready_o), .load_o(load), .sel_o(sel)
  );

  for (genvar k = 0; k < N; k++) begin : g_slot
    mirror_fork_slot slot_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .sel_i(sel[k]),
      .ready_i(out_ready_i[k]), .valid_o(out_valid_o[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (load) data_q <= in_data_i;
  end
  assign out_data_o = data_q;

  // R2
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (out_data_o == $past(in_data_i)));
  // R6
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o != '0) |-> !in_ready_o);
  // R7
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o != '0) |=> $stable(out_data_o));
endmodule

// File: tb/mirror_fork_tb_top.sv
module mirror_fork_tb_top;
  localparam int N = 4;
  localparam int DW = 16;

  logic clk = 0, rst_ni = 0;
  logic in_valid = 0;
  logic [DW-1:0] in_data = '0;
  logic [N-1:0] dst_mask = '0, out_ready = '0;
  logic in_ready;
  logic [N-1:0] out_valid;
  logic [DW-1:0] out_data;

  int vec = 0, bad = 0, cyc = 0;
  logic [N-1:0] m_pend;
  logic [DW-1:0] m_data;

  always #2 clk = ~clk;

  mirror_fork #(.N(N), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .dst_mask_i(dst_mask), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pend <= '0; m_data <= '0;
    end else if (m_pend == 0) begin
      if (in_valid) begin
        m_pend <= (dst_mask == 0) ? 4'hF : dst_mask;
        m_data <= in_data;
      end
    end else begin
      m_pend <= m_pend & ~out_ready;
    end
  end

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  // per-cycle compare, mid-low phase
  always @(negedge clk) if (rst_ni) begin
    cyc++;
    chk("R3/R4/R5", out_valid, m_pend);
    chk("R6", in_ready, m_pend == 0);
    if (m_pend != 0) chk("R2/R7", out_data, m_data);
  end

  task automatic step(input logic v, input logic [DW-1:0] d,
                      input logic [N-1:0] m, input logic [N-1:0] r);
    @(negedge clk);
    in_valid = v; in_data = d; dst_mask = m; out_ready = r;
  endtask

  initial begin
    #1;
    chk("R1", out_valid, 0);
    chk("R1", in_ready, 1);
    #9 rst_ni = 1;
    // R4 broadcast, staggered acks (R5, R7)
    step(1, 16'hA001, 4'h0, 4'h0);
    step(1, 16'hBEEF, 4'h5, 4'h1);    // R6 offered while busy
    step(0, 0, 0, 4'h4);
    step(0, 0, 0, 4'h0);
    step(0, 0, 0, 4'hA);              // R8 simultaneous last acks
    // R3 steer, back-to-back
    step(1, 16'h1234, 4'h6, 4'h0);
    step(1, 16'h5678, 4'h9, 4'h6);
    step(1, 16'h9ABC, 4'h8, 4'h9);
    step(0, 0, 0, 4'hF);
    // sweep
    for (int i = 0; i < 200; i++)
      step(i[0] | i[2], 16'(i * 37 + 5), 4'(i * 7), 4'(i * 11 + (i >> 2)));
    step(0, 0, 0, 4'hF);
    step(0, 0, 0, 0);
    @(negedge clk);
    chk("R8", in_ready, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #40000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule